// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags

This block is a purely combinational integer adder/subtractor of parameterised width. It takes two operands and a one-bit operation select. It returns the result word and four status flags:

- **carry**, correct for unsigned arithmetic;
- **overflow**, correct for two's-complement arithmetic;
- **zero**;
- **negative**.

Both operations share one ripple adder. For subtraction the second operand is bitwise inverted and the adder's carry-in is forced high. Carry on subtraction therefore reads as "no borrow", and subtracting zero reports carry set.

The unit sits in an execution stage. It holds no state: its outputs follow its inputs in the same cycle. It has no carry-in from a previous operation.

Top module: `addsub_unit`

## Requirements
- R1: With opSub = 0 the result equals (opA + opB) modulo 2^WIDTH; the bit carried out of the top position is not part of the result.
- R2: With opSub = 0 carryFlag equals the carry out of the most significant bit, i.e. bit WIDTH of the (WIDTH+1)-bit unsigned sum.
- R3: With opSub = 1 the result equals (opA - opB) modulo 2^WIDTH.
- R4: With opSub = 1 carryFlag is 1 exactly when opA >= opB as unsigned numbers (no borrow), so subtracting zero from any value sets it.
- R5: overflowFlag is 1 exactly when the true signed result of the selected operation, with both operands read as two's complement, lies outside the signed range of WIDTH bits.
- R6: zeroFlag is 1 exactly when every result bit is 0.
- R7: negFlag equals the result's most significant bit (bit WIDTH-1).
- R8: Subtracting an all-ones operand from itself gives a zero result with carryFlag = 1 and overflowFlag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (minuend for subtraction) |
| opB | input | WIDTH | Second operand (subtrahend for subtraction) |
| opSub | input | 1 | Operation select: 0 add, 1 subtract |
| result | output | WIDTH | Result word, truncated to WIDTH bits |
| carryFlag | output | 1 | Unsigned carry out; no-borrow on subtract |
| overflowFlag | output | 1 | Signed overflow |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Copy of the result sign bit |

## Verification
Carry and overflow can both be raised by a single operation, and zero can be raised alongside them. Adding the most negative value to itself gives carry = 1, overflow = 1 and zero = 1. Subtracting the most negative value from zero gives overflow without carry.

These coincidences come from an exhaustive sweep of a 4-bit instance over both operations. A 32-bit instance runs all ordered pairs of the corner values. Every flag is judged separately against a reference built from (WIDTH+1)-bit sums, unsigned comparison and exact signed integer arithmetic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // strobes the control hands to the datapath
  typedef struct packed {
    logic invertB;  // feed the bitwise complement of operand B
    logic carryIn;  // carry into bit 0 of the adder
  } addsub_ctrl_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic         opSub,
  output addsub_ctrl_t ctrl
);
  // subtraction: a + ~b + 1 on the shared adder; never pre-negate b
  always_comb begin
    ctrl.invertB = opSub;
    ctrl.carryIn = opSub;
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addsub_ctrl_t     ctrl,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             carryIntoMsb,
  output logic             bEffMsb
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;

  assign bEff    = opB ^ {WIDTH{ctrl.invertB}};
  assign bEffMsb = bEff[MSB];

  // ripple chain, bit by bit
  always_comb begin
    logic c;
    c            = ctrl.carryIn;
    carryIntoMsb = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == MSB) carryIntoMsb = c;
      sum[i] = opA[i] ^ bEff[i] ^ c;
      c      = (opA[i] & bEff[i]) | (c & (opA[i] ^ bEff[i]));
    end
    carryOut = c;
  end

  always_comb begin
    if (!ctrl.invertB) begin
      // R1 R2
      add_sum_chk: assert ({carryOut, sum} == ({1'b0, opA} + {1'b0, opB}));
    end else begin
      // R3
      sub_diff_chk: assert (sum == opA - opB);
      // R4
      sub_carry_chk: assert (carryOut == (opA >= opB));
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carryOut,
  input  logic             carryIntoMsb,
  input  logic             aMsb,
  input  logic             bEffMsb,
  output logic             carryFlag,
  output logic             overflowFlag,
  output logic             zeroFlag,
  output logic             negFlag
);
  localparam int MSB = WIDTH - 1;

  assign carryFlag    = carryOut;
  assign overflowFlag = carryIntoMsb ^ carryOut;
  assign zeroFlag     = ~|sum;
  assign negFlag      = sum[MSB];

  always_comb begin
    // R5: overflow shows as an impossible sign on the adder inputs
    no_overflow_chk: assert (overflowFlag == ((aMsb == bEffMsb) && (sum[MSB] != aMsb)));
    // R6 R7
    zero_sign_chk: assert (!(zeroFlag && negFlag));
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             opSub,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             overflowFlag,
  output logic             zeroFlag,
  output logic             negFlag
);
  localparam int MSB = WIDTH - 1;

  addsub_ctrl_t ctrl;
  logic         carryOut;
  logic         carryIntoMsb;
  logic         bEffMsb;

  addsub_ctrl u_ctrl (
    .opSub (opSub),
    .ctrl  (ctrl)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA          (opA),
    .opB          (opB),
    .ctrl         (ctrl),
    .sum          (result),
    .carryOut     (carryOut),
    .carryIntoMsb (carryIntoMsb),
    .bEffMsb      (bEffMsb)
  );

  addsub_flags #(.WIDTH(WIDTH)) u_flags (
    .sum          (result),
    .carryOut     (carryOut),
    .carryIntoMsb (carryIntoMsb),
    .aMsb         (opA[MSB]),
    .bEffMsb      (bEffMsb),
    .carryFlag    (carryFlag),
    .overflowFlag (overflowFlag),
    .zeroFlag     (zeroFlag),
    .negFlag      (negFlag)
  );

  always_comb begin
    // R8
    self_sub_chk: assert (!(opSub && (opA == opB)) || (zeroFlag && carryFlag && !overflowFlag));
  end
endmodule

// File: tb/addsub_unit_bench.sv
module addsub_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // small instance, swept exhaustively
  logic [3:0] aN = '0, bN = '0, resN;
  logic opN = 1'b0, cN, vN, zN, nN;
  // default-width instance, corner values
  logic [31:0] aW = '0, bW = '0, resW;
  logic opW = 1'b0, cW, vW, zW, nW;

  addsub_unit #(.WIDTH(4)) u_addsub_unit_small (
    .opA(aN), .opB(bN), .opSub(opN), .result(resN),
    .carryFlag(cN), .overflowFlag(vN), .zeroFlag(zN), .negFlag(nN));

  addsub_unit u_addsub_unit (
    .opA(aW), .opB(bW), .opSub(opW), .result(resW),
    .carryFlag(cW), .overflowFlag(vW), .zeroFlag(zW), .negFlag(nW));

  task automatic chk(input string req, input longint act, input longint exp,
                     input longint a, input longint b, input bit op);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h op=%0d actual=%0h expected=%0h", req, a, b, op, act, exp);
    end
  endtask

  task automatic runVec(input bit wide, input longint a, input longint b, input bit op);
    int w;
    longint mask, half, full, expRes, sa, sb, exact;
    bit expC, expV;
    longint actRes;
    bit actC, actV, actZ, actN;
    w    = wide ? 32 : 4;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    @(posedge clk);
    if (wide) begin aW = a[31:0]; bW = b[31:0]; opW = op; end
    else begin aN = a[3:0]; bN = b[3:0]; opN = op; end
    @(negedge clk);
    if (wide) begin actRes = longint'(resW); actC = cW; actV = vW; actZ = zW; actN = nW; end
    else begin actRes = longint'(resN); actC = cN; actV = vN; actZ = zN; actN = nN; end
    sa = (a >= half) ? a - 2*half : a;
    sb = (b >= half) ? b - 2*half : b;
    if (!op) begin
      full   = a + b;
      expRes = full & mask;
      expC   = ((full >> w) & 1) != 0;
      exact  = sa + sb;
      chk("R1 result", actRes, expRes, a, b, op);
      chk("R2 carry", longint'(actC), longint'(expC), a, b, op);
    end else begin
      expRes = (a - b) & mask;
      expC   = (a >= b);
      exact  = sa - sb;
      chk("R3 result", actRes, expRes, a, b, op);
      chk("R4 carry", longint'(actC), longint'(expC), a, b, op);
    end
    expV = (exact > half - 1) || (exact < -half);
    chk("R5 overflow", longint'(actV), longint'(expV), a, b, op);
    chk("R6 zero", longint'(actZ), longint'(expRes == 0), a, b, op);
    chk("R7 negative", longint'(actN), (expRes >> (w - 1)) & 1, a, b, op);
  endtask

  initial begin
    longint corners [6];
    corners = '{0, 1, 64'hFFFF_FFFF, 64'h7FFF_FFFF, 64'h8000_0000, 64'h1234_5678};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state: zero operands, add selected
    chk("R6 idle zero", longint'(zW), 1, 0, 0, 0);
    chk("R2 idle carry", longint'(cW), 0, 0, 0, 0);
    chk("R1 idle result", longint'(resW), 0, 0, 0, 0);
    rstN = 1'b1;
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          runVec(1'b0, longint'(a), longint'(b), op[0]);
    for (int op = 0; op < 2; op++)
      foreach (corners[i])
        foreach (corners[j])
          runVec(1'b1, corners[i], corners[j], op[0]);
    // R8: all-ones minus itself
    runVec(1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b1);
    chk("R8 zero", longint'(zW), 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    chk("R8 carry", longint'(cW), 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    chk("R8 overflow", longint'(vW), 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    // R4: subtracting zero keeps carry set
    runVec(1'b1, 64'h0, 64'h0, 1'b1);
    chk("R4 zero subtrahend", longint'(cW), 1, 0, 0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule